// File: doc/BRIEF.md
# JESD204B Transmit Link Sequencer

This block drives one transmit lane of a JESD204B link, one octet per clock, ahead of the 8b/10b encoder. Each octet comes with a flag that marks it as a control character. The block keeps a local multiframe counter and watches an active-low synchronization request from the receiver. It moves through three phases: comma transmission for code group synchronization, the four-multiframe initial lane alignment sequence, and user data.

The phase changes only on multiframe boundaries. The one exception is a renewed synchronization request, which wins at once. The alignment sequence is never scrambled. In the data phase the block forwards a user octet stream through a valid/ready handshake. It also raises a flag that tells the downstream scrambler to work on these octets. The octets per frame and the frames per multiframe are parameters. The link configuration values arrive on plain input ports.

Top module: `jesd_tx_link_seq`

## Requirements
- R1: While reset is held, and on every cycle after a clock edge that sampled `sync_n_i` low, the lane outputs octet 0xBC (K28.5) with `lane_ctrl_o`=1 and `tx_ready_o`=0. Reset leaves the block in the synchronization phase.
- R2: After `sync_n_i` goes high, K28.5 continues until the current multiframe ends. The alignment sequence starts on the first cycle of the next multiframe.
- R3: The multiframe counter starts at position 0 on the first cycle after reset and wraps every F_OCTETS×K_FRAMES cycles. The alignment sequence and the data phase therefore always start on a cycle whose count since reset is a multiple of that length.
- R4: The alignment sequence spans exactly four multiframes. In each multiframe, position 0 is 0x1C (K28.0) and the last position is 0x7C (K28.3), both with `lane_ctrl_o`=1.
- R5: In the second multiframe, position 1 is 0x9C (K28.4, control). Positions 2 to 15 carry configuration octets 0 to 13 with `lane_ctrl_o`=0.
- R6: Every other alignment-sequence position p carries the ramp value (p−1) mod 256 with `lane_ctrl_o`=0. Multiframes one, three and four have the same form.
- R7: The configuration octets, in index order, are:
  - 0: device id.
  - 1: 0x00.
  - 2: {000, lane id}.
  - 3: {scramble enable, 00, lanes−1}.
  - 4: F_OCTETS−1.
  - 5: {000, K_FRAMES−1}.
  - 6: converters−1.
  - 7: {000, resolution−1}.
  - 8: 0x2F.
  - 9: 0x20.
  - 10 to 12: 0x00.
  - 13: the sum modulo 256 of octets 0 to 12.
- R8: After the fourth multiframe, `tx_ready_o`=1 and `lane_ctrl_o`=0. `lane_octet_o` equals `tx_data_i` when `tx_valid_i`=1, and 0x00 otherwise.
- R9: `scramble_o` equals `scr_en_i` in the data phase. It is 0 in the synchronization phase and during the alignment sequence.
- R10: A synchronization request raised during the alignment sequence or the data phase returns the lane to K28.5 on the next cycle, with `tx_ready_o`=0. The next release restarts the sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane octet clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_n_i | input | 1 | Synchronization request from the receiver, active low |
| scr_en_i | input | 1 | Scrambling enabled for user data; also reported in the configuration |
| cfg_dev_id_i | input | 8 | Device identifier |
| cfg_lane_id_i | input | 5 | Lane identifier |
| cfg_lanes_i | input | 5 | Lane count (sent minus one) |
| cfg_conv_i | input | 8 | Converter count (sent minus one) |
| cfg_res_i | input | 5 | Converter resolution (sent minus one) |
| tx_data_i | input | 8 | User octet |
| tx_valid_i | input | 1 | User octet valid |
| tx_ready_o | output | 1 | Block accepts user octets (data phase) |
| lane_octet_o | output | 8 | Octet to the 8b/10b encoder |
| lane_ctrl_o | output | 1 | Octet is a control character |
| scramble_o | output | 1 | Downstream scrambler should process this octet |

## Verification
The bench releases the synchronization request at a position that is not a boundary. It then checks that comma transmission continues up to the boundary. A design that switched phase at once would start the alignment sequence off the multiframe grid. Every octet of all four multiframes is compared with a model built from R4 to R7. An off-by-one in the ramp, a configuration field sent without the minus one, or a wrong checksum would all show up there. The bench re-raises the request in the middle of the alignment sequence and again in the data phase. A design that waited for a boundary, or finished the sequence first, would keep sending data or fill octets after the request.

// File: rtl/jesd_seq_pkg.sv
package jesd_seq_pkg;
  typedef logic [7:0] octet_t;

  localparam octet_t K_COMMA  = 8'hBC;  // K28.5
  localparam octet_t K_START  = 8'h1C;  // K28.0
  localparam octet_t K_ALIGN  = 8'h7C;  // K28.3
  localparam octet_t K_CFGMRK = 8'h9C;  // K28.4
  localparam int     CFG_LEN  = 14;
  localparam int     CFG_POS0 = 2;      // first config slot in multiframe 2

  typedef enum logic [1:0] {
    PH_CGS  = 2'd0,
    PH_ILAS = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/jesd_lmfc_ctr.sv
module jesd_lmfc_ctr #(
  parameter int MF_LEN = 32,
  parameter int POS_W  = $clog2(MF_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [POS_W-1:0] pos_o,
  output logic             edge_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(MF_LEN - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (edge_o) pos_q <= '0;
    else             pos_q <= pos_q + 1'b1;
  end

  assign pos_o  = pos_q;
  assign edge_o = (pos_q == LAST);

  // R3
  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (pos_o == '0));
  a_r3_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o <= LAST);
endmodule

// File: rtl/jesd_ilas_gen.sv
module jesd_ilas_gen
  import jesd_seq_pkg::*;
#(
  parameter int F_OCTETS = 4,
  parameter int K_FRAMES = 8,
  parameter int MF_LEN   = F_OCTETS * K_FRAMES,
  parameter int POS_W    = $clog2(MF_LEN)
) (
  input  logic [1:0]       mf_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             scr_en_i,
  input  logic [7:0]       cfg_dev_id_i,
  input  logic [4:0]       cfg_lane_id_i,
  input  logic [4:0]       cfg_lanes_i,
  input  logic [7:0]       cfg_conv_i,
  input  logic [4:0]       cfg_res_i,
  output octet_t           octet_o,
  output logic             ctrl_o
);
  localparam logic [POS_W-1:0] LAST    = POS_W'(MF_LEN - 1);
  localparam logic [POS_W-1:0] CFG_LO  = POS_W'(CFG_POS0);
  localparam logic [POS_W-1:0] CFG_HI  = POS_W'(CFG_POS0 + CFG_LEN - 1);
  localparam logic [POS_W-1:0] Q_POS   = POS_W'(1);
  localparam octet_t F_M1 = 8'(F_OCTETS - 1);
  localparam logic [4:0] K_M1 = 5'(K_FRAMES - 1);

  octet_t cfg_oct [CFG_LEN];
  octet_t csum;

  always_comb begin
    cfg_oct[0]  = cfg_dev_id_i;
    cfg_oct[1]  = 8'h00;
    cfg_oct[2]  = {3'b000, cfg_lane_id_i};
    cfg_oct[3]  = {scr_en_i, 2'b00, cfg_lanes_i - 5'd1};
    cfg_oct[4]  = F_M1;
    cfg_oct[5]  = {3'b000, K_M1};
    cfg_oct[6]  = cfg_conv_i - 8'd1;
    cfg_oct[7]  = {3'b000, cfg_res_i - 5'd1};
    cfg_oct[8]  = 8'h2F;  // subclass 1, 16 bits per sample
    cfg_oct[9]  = 8'h20;  // version B, one sample per converter
    cfg_oct[10] = 8'h00;
    cfg_oct[11] = 8'h00;
    cfg_oct[12] = 8'h00;
    csum = 8'h00;
    for (int i = 0; i < CFG_LEN - 1; i++) csum = csum + cfg_oct[i];
    cfg_oct[CFG_LEN-1] = csum;
  end

  logic [POS_W-1:0] cfg_rel;
  assign cfg_rel = pos_i - CFG_LO;

  always_comb begin
    ctrl_o  = 1'b0;
    octet_o = 8'(pos_i) - 8'd1;  // ramp fill
    if (pos_i == '0) begin
      octet_o = K_START;
      ctrl_o  = 1'b1;
    end else if (pos_i == LAST) begin
      octet_o = K_ALIGN;
      ctrl_o  = 1'b1;
    end else if (mf_i == 2'd1 && pos_i == Q_POS) begin
      octet_o = K_CFGMRK;
      ctrl_o  = 1'b1;
    end else if (mf_i == 2'd1 && pos_i >= CFG_LO && pos_i <= CFG_HI) begin
      octet_o = cfg_oct[cfg_rel[3:0]];
    end
  end
endmodule

// File: rtl/jesd_tx_link_seq.sv
module jesd_tx_link_seq
  import jesd_seq_pkg::*;
#(
  parameter int F_OCTETS = 4,
  parameter int K_FRAMES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_n_i,
  input  logic       scr_en_i,
  input  logic [7:0] cfg_dev_id_i,
  input  logic [4:0] cfg_lane_id_i,
  input  logic [4:0] cfg_lanes_i,
  input  logic [7:0] cfg_conv_i,
  input  logic [4:0] cfg_res_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic [7:0] lane_octet_o,
  output logic       lane_ctrl_o,
  output logic       scramble_o
);
  // multiframe must hold /R/, /Q/, the config block and /A/
  localparam int MF_LEN = F_OCTETS * K_FRAMES;
  localparam int POS_W  = $clog2(MF_LEN);

  logic [POS_W-1:0] lmfc_pos;
  logic             lmfc_edge;
  phase_e           phase_q;
  logic [1:0]       mf_q;
  octet_t           ilas_octet;
  logic             ilas_ctrl;

  jesd_lmfc_ctr #(.MF_LEN(MF_LEN), .POS_W(POS_W)) i_lmfc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pos_o  (lmfc_pos),
    .edge_o (lmfc_edge)
  );

  jesd_ilas_gen #(
    .F_OCTETS(F_OCTETS), .K_FRAMES(K_FRAMES), .MF_LEN(MF_LEN), .POS_W(POS_W)
  ) i_ilas (
    .mf_i          (mf_q),
    .pos_i         (lmfc_pos),
    .scr_en_i      (scr_en_i),
    .cfg_dev_id_i  (cfg_dev_id_i),
    .cfg_lane_id_i (cfg_lane_id_i),
    .cfg_lanes_i   (cfg_lanes_i),
    .cfg_conv_i    (cfg_conv_i),
    .cfg_res_i     (cfg_res_i),
    .octet_o       (ilas_octet),
    .ctrl_o        (ilas_ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CGS;
      mf_q    <= '0;
    end else if (!sync_n_i) begin
      phase_q <= PH_CGS;
      mf_q    <= '0;
    end else if (lmfc_edge) begin
      unique case (phase_q)
        PH_CGS:  begin phase_q <= PH_ILAS; mf_q <= '0; end
        PH_ILAS: begin
          if (mf_q == 2'd3) phase_q <= PH_DATA;
          else              mf_q    <= mf_q + 2'd1;
        end
        default: phase_q <= phase_q;
      endcase
    end
  end

  always_comb begin
    tx_ready_o   = 1'b0;
    scramble_o   = 1'b0;
    lane_octet_o = K_COMMA;
    lane_ctrl_o  = 1'b1;
    unique case (phase_q)
      PH_ILAS: begin
        lane_octet_o = ilas_octet;
        lane_ctrl_o  = ilas_ctrl;
      end
      PH_DATA: begin
        tx_ready_o   = 1'b1;
        scramble_o   = scr_en_i;
        lane_octet_o = tx_valid_i ? tx_data_i : 8'h00;
        lane_ctrl_o  = 1'b0;
      end
      default: ;
    endcase
  end

  // R1 / R10
  a_r10_resync_comma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_n_i |=> (lane_octet_o == K_COMMA && lane_ctrl_o && !tx_ready_o));
  // R2
  a_r2_ilas_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_octet_o == K_START && lane_ctrl_o && $past(lane_octet_o == K_COMMA))
      |-> $past(lmfc_edge));
  // R3 / R8
  a_r8_data_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> $past(lmfc_edge));
  // R8
  a_r8_data_no_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !lane_ctrl_o);
  // R9
  a_r9_no_scramble_outside_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ready_o |-> !scramble_o);
endmodule

// File: tb/test_jesd_tx_link_seq.sv
module test_jesd_tx_link_seq;
  localparam int F_OCTETS = 4;
  localparam int K_FRAMES = 8;
  localparam int MF_LEN   = F_OCTETS * K_FRAMES;
  localparam int ILAS_LEN = 4 * MF_LEN;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_n_i = 1'b0;
  logic       scr_en_i = 1'b1;
  logic [7:0] cfg_dev_id_i = 8'h5A;
  logic [4:0] cfg_lane_id_i = 5'd3;
  logic [4:0] cfg_lanes_i = 5'd2;
  logic [7:0] cfg_conv_i = 8'd4;
  logic [4:0] cfg_res_i = 5'd14;
  logic [7:0] tx_data_i = 8'h00;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o;
  logic [7:0] lane_octet_o;
  logic       lane_ctrl_o;
  logic       scramble_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz
  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  jesd_tx_link_seq #(.F_OCTETS(F_OCTETS), .K_FRAMES(K_FRAMES)) i_jesd_tx_link_seq (
    .clk_i, .rst_ni, .sync_n_i, .scr_en_i, .cfg_dev_id_i, .cfg_lane_id_i,
    .cfg_lanes_i, .cfg_conv_i, .cfg_res_i, .tx_data_i, .tx_valid_i,
    .tx_ready_o, .lane_octet_o, .lane_ctrl_o, .scramble_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] cfg_exp(input int idx);
    logic [7:0] c [14];
    logic [7:0] s;
    c[0] = cfg_dev_id_i;  c[1] = 8'h00;  c[2] = {3'b0, cfg_lane_id_i};
    c[3] = {scr_en_i, 2'b00, 5'(cfg_lanes_i - 1)};
    c[4] = 8'(F_OCTETS - 1);  c[5] = 8'(K_FRAMES - 1);
    c[6] = 8'(cfg_conv_i - 1);  c[7] = {3'b0, 5'(cfg_res_i - 1)};
    c[8] = 8'h2F;  c[9] = 8'h20;  c[10] = 0;  c[11] = 0;  c[12] = 0;
    s = 0;
    for (int i = 0; i < 13; i++) s = s + c[i];
    c[13] = s;
    return c[idx];
  endfunction

  // expected ILAS octet at offset i (R4..R7)
  task automatic ilas_exp(input int i, output logic [7:0] oct, output logic ctl, output string req);
    int m = i / MF_LEN;
    int p = i % MF_LEN;
    if (p == 0)                      begin oct = 8'h1C; ctl = 1; req = "R4"; end
    else if (p == MF_LEN - 1)        begin oct = 8'h7C; ctl = 1; req = "R4"; end
    else if (m == 1 && p == 1)       begin oct = 8'h9C; ctl = 1; req = "R5"; end
    else if (m == 1 && p >= 2 && p <= 15) begin oct = cfg_exp(p - 2); ctl = 0; req = "R7"; end
    else                             begin oct = 8'(p - 1); ctl = 0; req = "R6"; end
  endtask

  task automatic expect_comma(input string req);
    chk(lane_octet_o == 8'hBC && lane_ctrl_o && !tx_ready_o, req,
        {tx_ready_o, lane_ctrl_o, lane_octet_o}, 10'h1BC);
  endtask

  // wait for the /R/ that opens the alignment sequence; comma until then
  task automatic wait_ilas_start();
    int n = 0;
    while (!(lane_octet_o == 8'h1C && lane_ctrl_o) && n <= MF_LEN + 1) begin
      expect_comma("R2");
      @(negedge clk_i);
      n++;
    end
    chk(n <= MF_LEN, "R2", n, MF_LEN);
    chk(cyc % MF_LEN == 0, "R3", cyc % MF_LEN, 0);
  endtask

  task automatic check_ilas(input int count);
    logic [7:0] eo;
    logic ec;
    string rq;
    for (int i = 0; i < count; i++) begin
      ilas_exp(i, eo, ec, rq);
      chk(lane_octet_o == eo && lane_ctrl_o == ec, rq, {lane_ctrl_o, lane_octet_o}, {ec, eo});
      chk(!scramble_o && !tx_ready_o, "R9", {tx_ready_o, scramble_o}, 0);
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    rst_ni = 0; sync_n_i = 0;
    repeat (3) @(negedge clk_i);
    expect_comma("R1");
    chk(!scramble_o, "R9", scramble_o, 0);
    rst_ni = 1;
  endtask

  task automatic t_cgs_hold();
    for (int i = 0; i < 2 * MF_LEN + 5; i++) begin
      @(negedge clk_i);
      expect_comma("R1");
    end
  endtask

  task automatic t_ilas_full();
    // release away from a boundary
    while (cyc % MF_LEN != 5) @(negedge clk_i);
    sync_n_i = 1;
    wait_ilas_start();
    check_ilas(ILAS_LEN);
  endtask

  task automatic t_data();
    chk(tx_ready_o && !lane_ctrl_o, "R8", {tx_ready_o, lane_ctrl_o}, 2'b10);
    chk(cyc % MF_LEN == 0, "R3", cyc % MF_LEN, 0);
    for (int i = 0; i < 20; i++) begin
      tx_data_i = 8'(i * 37 + 8'hBC);  // includes comma-valued data
      tx_valid_i = (i % 3 != 2);
      scr_en_i = (i < 10);
      #1;
      chk(lane_octet_o == (tx_valid_i ? tx_data_i : 8'h00) && !lane_ctrl_o, "R8",
          {lane_ctrl_o, lane_octet_o}, {1'b0, tx_valid_i ? tx_data_i : 8'h00});
      chk(scramble_o == scr_en_i, "R9", scramble_o, scr_en_i);
      @(negedge clk_i);
    end
    scr_en_i = 1;
    tx_valid_i = 0;
  endtask

  task automatic t_resync_data();
    sync_n_i = 0;
    @(negedge clk_i);
    expect_comma("R10");
    chk(!scramble_o, "R9", scramble_o, 0);
    repeat (7) @(negedge clk_i);
    expect_comma("R10");
    sync_n_i = 1;
    wait_ilas_start();
    check_ilas(ILAS_LEN);
    chk(tx_ready_o, "R8", tx_ready_o, 1);
  endtask

  task automatic t_resync_ilas();
    sync_n_i = 0;
    repeat (3) @(negedge clk_i);
    sync_n_i = 1;
    wait_ilas_start();
    check_ilas(MF_LEN + 9);  // stop inside the config block
    sync_n_i = 0;
    @(negedge clk_i);
    expect_comma("R10");
    sync_n_i = 1;
    wait_ilas_start();
    check_ilas(ILAS_LEN);
    chk(tx_ready_o && !lane_ctrl_o, "R8", {tx_ready_o, lane_ctrl_o}, 2'b10);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_cgs_hold();
    t_ilas_full();
    t_data();
    t_resync_data();
    t_resync_ilas();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule